// File: doc/BRIEF.md
# GPIO Interrupt Controller

A general-purpose pin controller for twelve pins, reached through a flat word-addressed register interface with a single-cycle write strobe and a combinational read port. Software picks each pin's direction and drives its output value; every pin's input level is brought into the clock domain by a two-stage synchronizer and can be read back at any time.

Each pin also feeds its own trigger detector. The detector can fire on a rising edge, a falling edge, either edge, a high level or a low level. A detector hit latches the pin's status bit when that pin is enabled. Status, enable and mask combine into one interrupt request line. Masking is done through two registers, one that sets mask bits and one that clears them, so that no read-modify-write is needed. A software reset register holds the whole block at its defaults for as long as it contains a one.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, `pad_oe` is all zero and `irq` is low.
- R2: The direction word (offset 0x20) drives `pad_oe`, and the output word (0x18) drives `pad_out`. Only bits 11:0 are stored, and higher bits read 0.
- R3: The input word (0x1C) returns, in bit n, the level on `pad_in[n]` two clock edges after it was applied.
- R4: Each pin has a 3-bit trigger code in a 4-bit nibble at bit pin*4 of a mode word. Pins 0 to 7 use the word at 0x24, and pins 8 to 11 use the word at 0x28, at nibble pin-8. The codes are: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 both edges, and 5 to 7 never fire. The top bit of each nibble is not stored and reads 0.
- R5: An edge event sets the pin's status bit (read at 0x04, bit n) at the third clock edge after the pad change. The bit stays set until it is cleared.
- R6: A level trigger sets status on every cycle the level is present. A clear written while the level persists leaves the bit set.
- R7: Status is latched only for pins whose enable bit (0x00) is set, whatever their mask.
- R8: A write of 1 to bit n at 0x10 masks pin n, and a write of 1 to bit n at 0x14 unmasks it. A 0 bit has no effect in either register. Both offsets read back the current mask.
- R9: The display word (0x08) reads status AND enable AND NOT mask. `irq` is high exactly when that word is non-zero.
- R10: A write of 1 to bit n at 0x0C clears status bit n of an edge-triggered pin.
- R11: While bit 0 of the word at 0x3C is 1, every other register stays at its reset value and ignores writes. That bit reads back at 0x3C, and writing 0 releases the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 12 | Pin levels from the pads |
| pad_out | output | 12 | Output values to the pads |
| pad_oe | output | 12 | Output enables, 1 = drive |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the clock edge that samples the strobe, so the bench reads back at the following falling edge. A pad change is visible in the input word after two edges and in status after three. Each pad step is therefore followed by at least that many idle edges before a read. Level triggers need one further edge after an enable write before status shows them, and the enable-then-read vectors include that edge.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // register byte offsets
    localparam int OFS_ENABLE  = 'h00;
    localparam int OFS_STATUS  = 'h04;
    localparam int OFS_DISPLAY = 'h08;
    localparam int OFS_CLEAR   = 'h0C;
    localparam int OFS_MSET    = 'h10;
    localparam int OFS_MCLR    = 'h14;
    localparam int OFS_OUT     = 'h18;
    localparam int OFS_IN      = 'h1C;
    localparam int OFS_DIR     = 'h20;
    localparam int OFS_MODE0   = 'h24;
    localparam int OFS_SWRST   = 'h3C;

    typedef enum logic [2:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_BOTH = 3'd4
    } trig_e;

    typedef struct packed {
        logic now_lvl;
        logic old_lvl;
    } pin_hist_t;

    function automatic logic trig_fires(logic [2:0] code, pin_hist_t h);
        logic f;
        case (code)
            TRIG_FALL: f = h.old_lvl & ~h.now_lvl;
            TRIG_RISE: f = ~h.old_lvl & h.now_lvl;
            TRIG_LOW:  f = ~h.now_lvl;
            TRIG_HIGH: f = h.now_lvl;
            TRIG_BOTH: f = h.old_lvl ^ h.now_lvl;
            default:   f = 1'b0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
    import gpio_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] code,
    input  logic       level,
    output logic       hit
);
    pin_hist_t hist;
    logic      prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb begin
        hist.now_lvl = level;
        hist.old_lvl = prev_q;
        hit          = trig_fires(code, hist);
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 12,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                irq
);
    localparam int PPW        = DATA_W / 4;
    localparam int MODE_WORDS = (NUM_PINS + PPW - 1) / PPW;

    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_ST   = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_DISP = ADDR_W'(OFS_DISPLAY);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(OFS_CLEAR);
    localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(OFS_MSET);
    localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(OFS_MCLR);
    localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFS_OUT);
    localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFS_IN);
    localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFS_DIR);
    localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(OFS_SWRST);

    logic                sw_hold;
    logic                blk_rst;
    logic [NUM_PINS-1:0] en_q, mask_q, stat_q, out_q, dir_q;
    logic [NUM_PINS-1:0] pin_sync, hit, clr_bits, disp;
    logic [2:0]          mode_q [NUM_PINS];
    logic                unused_wdata;

    assign blk_rst      = rst | sw_hold;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst)                          sw_hold <= 1'b0;
        else if (wr_en && addr == A_RST)  sw_hold <= wdata[0];
    end

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (blk_rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE0 + 4 * (p / PPW));

            always_ff @(posedge clk) begin
                if (blk_rst)                       mode_q[p] <= 3'd0;
                else if (wr_en && addr == A_MODE)  mode_q[p] <= wdata[(p % PPW) * 4 +: 3];
            end

            gpio_trig_det u_det (
                .clk   (clk),
                .rst   (blk_rst),
                .code  (mode_q[p]),
                .level (pin_sync[p]),
                .hit   (hit[p])
            );

            assert_stat_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
                $rose(stat_q[p]) |-> $past(en_q[p]));

            assert_rise_seen_R5: assert property (@(posedge clk) disable iff (rst)
                ($rose(stat_q[p]) && mode_q[p] == TRIG_RISE && $past(mode_q[p]) == TRIG_RISE)
                    |-> $past(pin_sync[p]));
        end
    endgenerate

    assign clr_bits = (wr_en && addr == A_CLR) ? wdata[NUM_PINS-1:0] : '0;

    always_ff @(posedge clk) begin
        if (blk_rst) begin
            en_q   <= '0;
            mask_q <= '0;
            stat_q <= '0;
            out_q  <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_en && addr == A_EN)   en_q   <= wdata[NUM_PINS-1:0];
            if (wr_en && addr == A_MSET) mask_q <= mask_q | wdata[NUM_PINS-1:0];
            if (wr_en && addr == A_MCLR) mask_q <= mask_q & ~wdata[NUM_PINS-1:0];
            if (wr_en && addr == A_OUT)  out_q  <= wdata[NUM_PINS-1:0];
            if (wr_en && addr == A_DIR)  dir_q  <= wdata[NUM_PINS-1:0];
            // a detector hit in the same cycle wins over a clear
            stat_q <= (stat_q & ~clr_bits) | (hit & en_q);
        end
    end

    assign disp    = stat_q & en_q & ~mask_q;
    assign irq     = |disp;
    assign pad_out = out_q;
    assign pad_oe  = dir_q;

    always_comb begin
        rdata = '0;
        case (addr)
            A_EN:           rdata = DATA_W'(en_q);
            A_ST:           rdata = DATA_W'(stat_q);
            A_DISP:         rdata = DATA_W'(disp);
            A_MSET, A_MCLR: rdata = DATA_W'(mask_q);
            A_OUT:          rdata = DATA_W'(out_q);
            A_IN:           rdata = DATA_W'(pin_sync);
            A_DIR:          rdata = DATA_W'(dir_q);
            A_RST:          rdata = DATA_W'(sw_hold);
            default: begin
                for (int w = 0; w < MODE_WORDS; w++) begin
                    if (addr == ADDR_W'(OFS_MODE0 + 4 * w)) begin
                        for (int p = 0; p < NUM_PINS; p++) begin
                            if (p / PPW == w) rdata[(p % PPW) * 4 +: 3] = mode_q[p];
                        end
                    end
                end
            end
        endcase
    end

    assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MSET && !sw_hold)
            |=> ((mask_q & $past(wdata[NUM_PINS-1:0])) == $past(wdata[NUM_PINS-1:0])));

    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == A_MCLR && !sw_hold)
            |=> ((mask_q & $past(wdata[NUM_PINS-1:0])) == '0));

    assert_swrst_hold_R11: assert property (@(posedge clk) disable iff (rst)
        sw_hold |=> (en_q == '0 && stat_q == '0 && mask_q == '0 && dir_q == '0 && !irq));

endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
    localparam int NP = 12;
    localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PAD = 2'd2, OP_IDLE = 2'd3;
    localparam int NV = 63;

    // {op, requirement number, address, data, expected}
    localparam logic [77:0] VEC [NV] = '{
        {OP_RD,   4'd1,  8'h00, 32'h0,        32'h0},        // R1
        {OP_RD,   4'd1,  8'h20, 32'h0,        32'h0},        // R1
        {OP_WR,   4'd2,  8'h20, 32'hFFFFF00F, 32'h0},        // R2
        {OP_RD,   4'd2,  8'h20, 32'h0,        32'h00F},      // R2 high bits dropped
        {OP_WR,   4'd2,  8'h18, 32'h00000A5A, 32'h0},        // R2
        {OP_RD,   4'd2,  8'h18, 32'h0,        32'hA5A},      // R2
        {OP_PAD,  4'd3,  8'h00, 32'h5C3,      32'h0},        // R3
        {OP_IDLE, 4'd3,  8'h00, 32'd2,        32'h0},        // R3 two edges
        {OP_RD,   4'd3,  8'h1C, 32'h0,        32'h5C3},      // R3
        {OP_WR,   4'd4,  8'h24, 32'h00523409, 32'h0},        // R4 codes for pins 0..7
        {OP_RD,   4'd4,  8'h24, 32'h0,        32'h00523401}, // R4 nibble top bit dropped
        {OP_WR,   4'd4,  8'h28, 32'hFFFFFFFF, 32'h0},        // R4
        {OP_RD,   4'd4,  8'h28, 32'h0,        32'h00007777}, // R4 only pins 8..11
        {OP_WR,   4'd4,  8'h28, 32'h00001111, 32'h0},        // R4 pins 8..11 rising
        {OP_RD,   4'd4,  8'h28, 32'h0,        32'h00001111}, // R4
        {OP_PAD,  4'd7,  8'h00, 32'h000,      32'h0},        // R7 edges while disabled
        {OP_IDLE, 4'd7,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd7,  8'h04, 32'h0,        32'h0},        // R7 nothing latched
        {OP_WR,   4'd7,  8'h00, 32'hFFFFFFFF, 32'h0},        // R7 enable all
        {OP_IDLE, 4'd6,  8'h00, 32'd1,        32'h0},
        {OP_RD,   4'd6,  8'h04, 32'h0,        32'h010},      // R6 low level pin 4
        {OP_WR,   4'd6,  8'h0C, 32'h010,      32'h0},        // R6 clear while low
        {OP_RD,   4'd6,  8'h04, 32'h0,        32'h010},      // R6 still set
        {OP_RD,   4'd9,  8'h08, 32'h0,        32'h010},      // R9
        {OP_WR,   4'd8,  8'h10, 32'h010,      32'h0},        // R8 mask pin 4
        {OP_RD,   4'd9,  8'h08, 32'h0,        32'h0},        // R9 masked
        {OP_RD,   4'd8,  8'h10, 32'h0,        32'h010},      // R8
        {OP_RD,   4'd8,  8'h14, 32'h0,        32'h010},      // R8
        {OP_WR,   4'd8,  8'h10, 32'h0,        32'h0},        // R8 zero no effect
        {OP_WR,   4'd8,  8'h14, 32'h0,        32'h0},        // R8 zero no effect
        {OP_RD,   4'd8,  8'h14, 32'h0,        32'h010},      // R8
        {OP_WR,   4'd8,  8'h14, 32'h010,      32'h0},        // R8 unmask
        {OP_RD,   4'd8,  8'h10, 32'h0,        32'h0},        // R8
        {OP_PAD,  4'd5,  8'h00, 32'h019,      32'h0},        // R5 pins 0,3,4 high
        {OP_IDLE, 4'd5,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd5,  8'h04, 32'h0,        32'h019},      // R5 rise, high, pin 4 held
        {OP_WR,   4'd10, 8'h0C, 32'h019,      32'h0},        // R10
        {OP_RD,   4'd10, 8'h04, 32'h0,        32'h008},      // R10 level pin 3 remains
        {OP_PAD,  4'd4,  8'h00, 32'h006,      32'h0},        // R4 both-edge and low
        {OP_IDLE, 4'd4,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd4,  8'h04, 32'h0,        32'h01C},      // R4
        {OP_WR,   4'd10, 8'h0C, 32'h00C,      32'h0},        // R10
        {OP_RD,   4'd10, 8'h04, 32'h0,        32'h010},      // R10
        {OP_PAD,  4'd4,  8'h00, 32'h000,      32'h0},        // R4 falls on pins 1,2
        {OP_IDLE, 4'd4,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd4,  8'h04, 32'h0,        32'h016},      // R4
        {OP_PAD,  4'd4,  8'h00, 32'h020,      32'h0},        // R4 code 5 pin toggles
        {OP_IDLE, 4'd4,  8'h00, 32'd3,        32'h0},
        {OP_PAD,  4'd4,  8'h00, 32'h000,      32'h0},
        {OP_IDLE, 4'd4,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd4,  8'h04, 32'h0,        32'h016},      // R4 code 5 never fires
        {OP_PAD,  4'd5,  8'h00, 32'h100,      32'h0},        // R5 pin 8 rise
        {OP_IDLE, 4'd5,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd5,  8'h04, 32'h0,        32'h116},      // R5
        {OP_WR,   4'd7,  8'h00, 32'h00000EFF, 32'h0},        // R7 disable pin 8
        {OP_WR,   4'd7,  8'h0C, 32'h100,      32'h0},
        {OP_PAD,  4'd7,  8'h00, 32'h000,      32'h0},
        {OP_IDLE, 4'd7,  8'h00, 32'd3,        32'h0},
        {OP_PAD,  4'd7,  8'h00, 32'h100,      32'h0},
        {OP_IDLE, 4'd7,  8'h00, 32'd3,        32'h0},
        {OP_RD,   4'd7,  8'h04, 32'h0,        32'h016},      // R7 disabled pin ignored
        {OP_WR,   4'd9,  8'h10, 32'h006,      32'h0},        // R9 mask pins 1,2
        {OP_RD,   4'd9,  8'h08, 32'h0,        32'h010}       // R9
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe;
    logic          irq;
    int            n_chk = 0;
    int            n_bad = 0;

    always #4ns clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .irq     (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1ns;
        d = rdata;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pad_oe", 32'(pad_oe), 32'h0);
        check("R1 irq", 32'(irq), 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [7:0]  a;
            logic [31:0] d, e;
            {op, rq, a, d, e} = VEC[i];
            case (op)
                OP_WR:   reg_wr(a, d);
                OP_PAD:  pad_in = d[NP-1:0];
                OP_IDLE: repeat (d) @(negedge clk);
                default: begin
                    reg_rd(a, got);
                    check($sformatf("R%0d vector %0d", rq, i), got, e);
                end
            endcase
        end

        // directed: pin drive and interrupt line
        @(negedge clk);
        check("R2 pad_oe", 32'(pad_oe), 32'h00F);
        check("R2 pad_out", 32'(pad_out), 32'hA5A);
        check("R9 irq high", 32'(irq), 32'h1);
        reg_wr(8'h10, 32'hFFF);
        #1ns;
        check("R9 irq masked", 32'(irq), 32'h0);

        // directed: software reset hold and release (R11)
        reg_wr(8'h3C, 32'h1);
        reg_wr(8'h20, 32'hFFF);
        reg_rd(8'h3C, got); check("R11 hold reads 1", got, 32'h1);
        reg_rd(8'h20, got); check("R11 write ignored", got, 32'h0);
        reg_rd(8'h04, got); check("R11 status cleared", got, 32'h0);
        reg_rd(8'h10, got); check("R11 mask cleared", got, 32'h0);
        check("R11 pad_oe", 32'(pad_oe), 32'h0);
        reg_wr(8'h3C, 32'h0);
        reg_rd(8'h3C, got); check("R11 released", got, 32'h0);
        reg_wr(8'h20, 32'h3);
        reg_rd(8'h20, got); check("R11 writes resume", got, 32'h3);

        finish_run();
    end
endmodule